// File: doc/BRIEF.md
# Double-Data-Rate Input Capture Register

This block takes a data bus that changes twice per clock period, once around each clock edge, and turns it into two parallel buses, `q1` and `q2`, that the rest of the logic can use. One flop bank samples the bus on the rising edge and a second bank samples it on the falling edge. A static parameter then picks how those two samples reach the outputs. In the mixed-edge mode each output follows its own edge. In the two rising-edge modes the falling sample is moved into the rising-edge domain inside the block, so downstream logic needs only one clock edge.

The two rising-edge modes trade latency against pairing. The skewed mode adds no delay to `q1`, but what it presents is the newest rising sample next to the falling sample taken half a cycle earlier. The aligned mode spends one more rising-edge stage on `q1`, so each rising sample appears next to the falling sample that directly followed it. The interface is free-running with no handshake: a new pair is offered every cycle, and the block cannot apply back-pressure. A consumer that stalls loses data. Each bit of the bus is handled on its own with identical timing.

Top module: `ddr_in_capture`

## Requirements
- R1: The parameter `PAIR_MODE` selects one of three fixed behaviours: `PAIR_MIXED`, `PAIR_SKEWED` or `PAIR_ALIGNED`. The selection cannot change at run time.
- R2: `rst` is active high and synchronous. While it is held, every rising edge clears `q1` and every falling edge clears `q2` (mixed mode), and every rising edge clears both outputs (other modes). All outputs read zero after a few cycles of reset.
- R3: In `PAIR_MIXED`, after each rising edge `q1` equals the value of `d` sampled at that rising edge.
- R4: In `PAIR_MIXED`, after each falling edge `q2` equals the value of `d` sampled at that falling edge.
- R5: In `PAIR_SKEWED`, after rising edge k, `q1` equals `d` at rising edge k and `q2` equals `d` at the falling edge just before rising edge k.
- R6: In `PAIR_SKEWED`, the first pair after reset release has `q2` equal to zero.
- R7: In `PAIR_ALIGNED`, after rising edge k, `q1` equals `d` at rising edge k-1 and `q2` equals `d` at the falling edge between rising edges k-1 and k. `q1` therefore has one more cycle of latency than in `PAIR_SKEWED`.
- R8: In `PAIR_ALIGNED`, the first pair after reset release is zero on both outputs.
- R9: Every bit of the `WIDTH`-bit bus follows R3 to R8 independently. Differing values on neighbouring bits do not disturb one another.
- R10: In `PAIR_SKEWED` and `PAIR_ALIGNED`, neither output changes at a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges sample `d` |
| rst | input | 1 | Synchronous reset, active high |
| d | input | WIDTH | Double-rate data bus |
| q1 | output | WIDTH | Rising-edge sample stream |
| q2 | output | WIDTH | Falling-edge sample stream |

## Verification
The bench drives three copies of the block, one per mode, with the same two-samples-per-cycle sequence. It compares every pair against a queue of expected rising and falling samples.

The bench targets the following corner cases:
- **Pairing skew.** A skewed copy that paired naturally, or an aligned copy that stayed skewed, would show `q1` one sample off.
- **First pair after reset release.** A retiming stage that is not cleared would leak a stale falling sample into it.
- **Falling-edge timing of the rising-domain outputs.** A rising-domain output that was wired straight to the falling flop would change mid-cycle.
- **Bit independence.** Alternating, constant, walking and pseudo-random patterns would expose any mixing of lanes.

// File: rtl/ddr_in_pkg.sv
package ddr_in_pkg;

  // Output pairing behaviour, chosen at elaboration time.
  typedef enum logic [1:0] {
    PAIR_MIXED   = 2'd0,  // q1 on rising edge, q2 on falling edge
    PAIR_SKEWED  = 2'd1,  // both on rising edge, falling sample lags by half a pair
    PAIR_ALIGNED = 2'd2   // both on rising edge, natural pair, extra cycle of latency
  } pair_mode_e;

  // Number of rising-edge stages between the rising capture flop and q1.
  function automatic int unsigned q1_extra_stages(pair_mode_e m);
    return (m == PAIR_ALIGNED) ? 1 : 0;
  endfunction

endpackage

// File: rtl/ddr_edge_sampler.sv
module ddr_edge_sampler #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] rise_smp,
  output logic [WIDTH-1:0] fall_smp
);

  // One rising and one falling flop per lane; lanes never interact.
  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    logic rise_r;
    logic fall_r;

    always_ff @(posedge clk) begin
      if (rst) rise_r <= 1'b0;
      else     rise_r <= d[b];
    end

    always_ff @(negedge clk) begin
      if (rst) fall_r <= 1'b0;
      else     fall_r <= d[b];
    end

    assign rise_smp[b] = rise_r;
    assign fall_smp[b] = fall_r;
  end

endmodule

// File: rtl/ddr_pair_align.sv
module ddr_pair_align
  import ddr_in_pkg::*;
#(
  parameter int unsigned WIDTH     = 1,
  parameter pair_mode_e  PAIR_MODE = PAIR_ALIGNED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rise_smp,
  input  logic [WIDTH-1:0] fall_smp,
  output logic [WIDTH-1:0] q1,
  output logic [WIDTH-1:0] q2
);

  localparam int unsigned Q1_STAGES = q1_extra_stages(PAIR_MODE);

  if (PAIR_MODE == PAIR_MIXED) begin : g_mixed
    // Each output stays in the domain of the edge that captured it.
    assign q1 = rise_smp;
    assign q2 = fall_smp;
  end else begin : g_same
    // Falling sample is retimed into the rising domain.
    logic [WIDTH-1:0] q2_r;
    always_ff @(posedge clk) begin
      if (rst) q2_r <= '0;
      else     q2_r <= fall_smp;
    end
    assign q2 = q2_r;

    if (Q1_STAGES == 0) begin : g_q1_direct
      assign q1 = rise_smp;
    end else begin : g_q1_delay
      // Extra rising stage lets the rising sample wait for its partner.
      logic [WIDTH-1:0] q1_pipe [Q1_STAGES];
      for (genvar s = 0; s < Q1_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst)         q1_pipe[s] <= '0;
          else if (s == 0) q1_pipe[s] <= rise_smp;
          else             q1_pipe[s] <= q1_pipe[(s == 0) ? 0 : s-1];
        end
      end
      assign q1 = q1_pipe[Q1_STAGES-1];
    end
  end

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddr_in_pkg::*;
#(
  parameter int unsigned WIDTH     = 1,
  parameter pair_mode_e  PAIR_MODE = PAIR_ALIGNED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q1,
  output logic [WIDTH-1:0] q2
);

  logic [WIDTH-1:0] rise_smp;
  logic [WIDTH-1:0] fall_smp;

  ddr_edge_sampler #(
    .WIDTH (WIDTH)
  ) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .d        (d),
    .rise_smp (rise_smp),
    .fall_smp (fall_smp)
  );

  ddr_pair_align #(
    .WIDTH     (WIDTH),
    .PAIR_MODE (PAIR_MODE)
  ) u_align (
    .clk      (clk),
    .rst      (rst),
    .rise_smp (rise_smp),
    .fall_smp (fall_smp),
    .q1       (q1),
    .q2       (q2)
  );

  // Rising edges since reset release, saturating; gates the checks below.
  logic [1:0] settled;
  always_ff @(posedge clk) begin
    if (rst)                 settled <= 2'd0;
    else if (settled != 2'd3) settled <= settled + 2'd1;
  end

  // R4 R5 R7: in every mode q2 seen at a falling edge is the previous falling-edge input
  property q2_fall_p;
    @(negedge clk) disable iff (rst) (settled == 2'd3) |-> (q2 == $past(d));
  endproperty
  // R4
  q2_fall_chk: assert property (q2_fall_p);

  if (PAIR_MODE == PAIR_ALIGNED) begin : g_chk_aligned
    // R7
    aligned_q1_chk: assert property (@(posedge clk) disable iff (rst)
      (settled == 2'd3) |-> (q1 == $past(d, 2)));
  end else if (PAIR_MODE == PAIR_SKEWED) begin : g_chk_skewed
    // R5
    skewed_q1_chk: assert property (@(posedge clk) disable iff (rst)
      (settled == 2'd3) |-> (q1 == $past(d)));
  end else begin : g_chk_mixed
    // R3
    mixed_q1_chk: assert property (@(posedge clk) disable iff (rst)
      (settled == 2'd3) |-> (q1 == $past(d)));
  end

endmodule

// File: tb/sim_ddr_in_capture.sv
module sim_ddr_in_capture;
  import ddr_in_pkg::*;

  localparam int W      = 4;
  localparam int NCYC   = 48;

  typedef struct packed {
    logic [W-1:0] r;
    logic [W-1:0] f;
  } pair_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] d   = '0;
  logic [W-1:0] q1_m, q2_m, q1_s, q2_s, q1_a, q2_a;

  int checks = 0;
  int errors = 0;
  pair_t exp_q[$];

  always #5 clk = ~clk;

  ddr_in_capture #(.WIDTH(W), .PAIR_MODE(PAIR_MIXED)) u0 (
    .clk(clk), .rst(rst), .d(d), .q1(q1_m), .q2(q2_m));
  ddr_in_capture #(.WIDTH(W), .PAIR_MODE(PAIR_SKEWED)) u1 (
    .clk(clk), .rst(rst), .d(d), .q1(q1_s), .q2(q2_s));
  ddr_in_capture #(.WIDTH(W), .PAIR_MODE(PAIR_ALIGNED)) u2 (
    .clk(clk), .rst(rst), .d(d), .q1(q1_a), .q2(q2_a));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: patterns differ per lane: alternating, constant, walking, pseudo-random
  function automatic pair_t make_pair(input int k, inout logic [7:0] lfsr);
    pair_t p;
    if (k < 8) begin
      p.r = (k % 2 == 0) ? 4'hA : 4'h5;
      p.f = ~p.r;
    end else if (k < 16) begin
      p.r = (k < 12) ? 4'hF : 4'h0;
      p.f = (k < 12) ? 4'h0 : 4'hF;
    end else if (k < 24) begin
      p.r = 4'(1 << (k % 4));
      p.f = 4'(8 >> (k % 4));
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      p.r  = lfsr[3:0];
      p.f  = lfsr[7:4];
    end
    return p;
  endfunction

  task automatic driver();
    logic [7:0] lfsr = 8'h5B;
    for (int k = 0; k < NCYC; k++) begin
      pair_t p = make_pair(k, lfsr);
      d = p.r;                 // sampled at the coming rising edge
      @(posedge clk);
      #1 exp_q.push_back(p);
      #1 d = p.f;              // sampled at the coming falling edge
      @(negedge clk);
      #2;
    end
  endtask

  task automatic monitor();
    pair_t prev = '0;
    for (int k = 0; k < NCYC; k++) begin
      pair_t cur;
      logic [W-1:0] s1, s2, a1, a2;
      @(posedge clk);
      #3;
      cur = exp_q.pop_front();
      check("R3 mixed q1", q1_m, cur.r);
      check("R5 skewed q1", q1_s, cur.r);
      if (k == 0) begin
        check("R6 skewed first q2", q2_s, '0);
        check("R8 aligned first q1", q1_a, '0);
        check("R8 aligned first q2", q2_a, '0);
      end else begin
        check("R5 skewed q2", q2_s, prev.f);
        check("R7 aligned q1", q1_a, prev.r);
        check("R7 aligned q2", q2_a, prev.f);
      end
      s1 = q1_s; s2 = q2_s; a1 = q1_a; a2 = q2_a;
      @(negedge clk);
      #3;
      check("R4 mixed q2", q2_m, cur.f);
      check("R3 mixed q1 held", q1_m, cur.r);
      check("R10 skewed q1 hold", q1_s, s1);
      check("R10 skewed q2 hold", q2_s, s2);
      check("R10 aligned q1 hold", q1_a, a1);
      check("R10 aligned q2 hold", q2_a, a2);
      prev = cur;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    d = 4'hC;
    repeat (4) @(posedge clk);
    #3;
    // R2: all outputs cleared in every mode (R1 selects each copy's mode)
    check("R2 mixed q1 reset", q1_m, '0);
    check("R2 mixed q2 reset", q2_m, '0);
    check("R2 skewed q1 reset", q1_s, '0);
    check("R2 skewed q2 reset", q2_s, '0);
    check("R2 aligned q1 reset", q1_a, '0);
    check("R2 aligned q2 reset", q2_a, '0);
    @(negedge clk);
    #1 rst = 1'b0;
    #1;
    fork
      driver();
      monitor();
    join
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule